// File: doc/BRIEF.md
# Three-Stream Symbol Time Multiplexer

This block lets three parallel complex sample streams share one downstream processor that runs at three times their sample rate. Each stream is written, one sample per write-clock cycle in which its valid is high, into its own dual-port buffer that holds two symbols of `SYM_LEN` samples. While one half of each buffer fills, the other half holds the last finished symbol.

Once a whole symbol has been written, a toggle crosses into the fast read clock domain through a synchronizer. The reader then plays out the finished symbol of stream 0 in full, then that of stream 1, then that of stream 2. These come out as one interleaved stream, and every sample carries a 2-bit tag naming its source stream.

Results that the shared processor returns, tagged the same way, are routed back. Each one loads the matching per-stream result register and raises that stream's one-cycle valid flag.

Top module: `tri_stream_tdm`

## Requirements
- R1: While reset is held, and right after it, `out_vld` is 0, `res_q_vld` is 0 and every `res_q` entry is 0.
- R2: Readout of a symbol starts only after all `SYM_LEN` samples of that symbol have been accepted. A partly written symbol produces no output.
- R3: A symbol is played out as stream 0, then stream 1, then stream 2, with sample indices 0 to `SYM_LEN`-1 in order within each stream. `out_tag` carries the stream number (0, 1 or 2) of each output sample and never takes the value 3.
- R4: Once a readout starts, `out_vld` stays high for 3Γ—`SYM_LEN` consecutive read-clock cycles, starting at tag 0 and ending at tag 2.
- R5: Each output sample equals the sample written at that stream and index in the same symbol. Symbols come out in the order they were written, using alternating buffer halves.
- R6: A write-clock cycle with `in_vld` all zero writes nothing and does not advance the sample index. The three valid bits are driven either all high or all low.
- R7: A result with `res_in_vld` high and tag t in {0,1,2} loads `res_q[t]` on the next read-clock edge and pulses `res_q_vld[t]` for exactly that one cycle. The other streams' registers and flags are left unchanged.
- R8: A result tagged 3 changes no `res_q` entry and raises no `res_q_vld` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Input sample clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| in_vld | input | 3 | Per-stream sample valid (all equal) |
| in_re | input | 3Γ—SAMP_W | Real parts of the three input samples |
| in_im | input | 3Γ—SAMP_W | Imaginary parts of the three input samples |
| rd_clk | input | 1 | Fast clock, three times the input rate |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| out_vld | output | 1 | Interleaved output sample valid |
| out_tag | output | 2 | Stream number of the output sample |
| out_re | output | SAMP_W | Real part of output sample |
| out_im | output | SAMP_W | Imaginary part of output sample |
| res_in_vld | input | 1 | Returning result valid |
| res_in_tag | input | 2 | Stream number of the returning result |
| res_in_data | input | RES_W | Returning result value |
| res_q | output | 3Γ—RES_W | Per-stream result registers |
| res_q_vld | output | 3 | One-cycle per-stream result load flags |

## Verification
The assertions assume that the three input valids move together. The bench drives them from a single flag, so every cycle either writes all three streams or none. The assertions also assume that the read clock is exactly three times the write clock and that one readout ends before the next symbol completes. The bench keeps to this by deriving both clocks from a fixed 1:3 period relation and by never completing symbols faster than one per `SYM_LEN` write cycles. Idle cycles are inserted within and between symbols.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

    localparam int NUM_STREAMS = 3;
    localparam int TAG_W       = 2;

    typedef logic [TAG_W-1:0] tag_t;

    // Read-side sequencing state
    typedef struct packed {
        logic busy;
        tag_t strm;
        logic bank;
    } rd_state_t;

    // Output lane qualifiers, one cycle behind the buffer address
    typedef struct packed {
        logic vld;
        tag_t tag;
    } lane_t;

    function automatic logic is_stream(tag_t t, int s);
        return t == tag_t'(s);
    endfunction

endpackage

// File: rtl/tsm_dpram.sv
module tsm_dpram #(
    parameter int DW = 24,
    parameter int AW = 7
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rd_clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge wr_clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rd_clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tsm_writer.sv
module tsm_writer #(
    parameter int NS      = 3,
    parameter int SYM_LEN = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NS-1:0]               in_vld,
    output logic                        we,
    output logic [$clog2(SYM_LEN):0]    waddr,
    output logic                        done_tog
);
    localparam int IDX_W = $clog2(SYM_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_LEN - 1);

    logic [IDX_W-1:0] idx;
    logic             bank;

    assign we       = &in_vld;
    assign waddr    = {bank, idx};
    assign done_tog = bank;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx  <= '0;
            bank <= 1'b0;
        end else if (we) begin
            if (idx == LAST_IDX) begin
                idx  <= '0;
                bank <= ~bank;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tsm_reader.sv
module tsm_reader
    import tsm_pkg::*;
#(
    parameter int NS      = 3,
    parameter int SYM_LEN = 64,
    parameter int DW      = 24
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        done_tog,
    input  logic [NS-1:0][DW-1:0]       rdata,
    output logic                        ren,
    output logic [$clog2(SYM_LEN):0]    raddr,
    output logic                        out_vld,
    output tag_t                        out_tag,
    output logic [DW-1:0]               out_data
);
    localparam int IDX_W = $clog2(SYM_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SYM_LEN - 1);
    localparam tag_t LAST_STRM = tag_t'(NS - 1);

    logic [2:0]       sync_q;
    logic             start;
    rd_state_t        st;
    logic [IDX_W-1:0] idx;
    lane_t            lane;

    assign start = sync_q[1] ^ sync_q[2];
    assign ren   = st.busy;
    assign raddr = {st.bank, idx};

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            st     <= '0;
            idx    <= '0;
            lane   <= '0;
        end else begin
            sync_q   <= {sync_q[1:0], done_tog};
            lane.vld <= st.busy;
            lane.tag <= st.strm;
            if (st.busy) begin
                if (idx == LAST_IDX) begin
                    idx <= '0;
                    if (st.strm == LAST_STRM) begin
                        st.busy <= 1'b0;
                        st.strm <= '0;
                        st.bank <= ~st.bank;
                    end else begin
                        st.strm <= st.strm + 1'b1;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end else if (start) begin
                st.busy <= 1'b1;
            end
        end
    end

    assign out_vld = lane.vld;
    assign out_tag = lane.tag;

    always_comb begin
        out_data = '0;
        for (int i = 0; i < NS; i++) begin
            if (is_stream(lane.tag, i)) out_data = rdata[i];
        end
    end
endmodule

// File: rtl/tsm_demux.sv
module tsm_demux
    import tsm_pkg::*;
#(
    parameter int NS    = 3,
    parameter int RES_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     res_vld,
    input  tag_t                     res_tag,
    input  logic [RES_W-1:0]         res_data,
    output logic [NS-1:0][RES_W-1:0] res_q,
    output logic [NS-1:0]            res_q_vld
);
    for (genvar g = 0; g < NS; g++) begin : g_lane
        logic hit;
        assign hit = res_vld && is_stream(res_tag, g);

        always_ff @(posedge clk) begin
            if (rst) begin
                res_q[g]     <= '0;
                res_q_vld[g] <= 1'b0;
            end else begin
                res_q_vld[g] <= hit;
                if (hit) res_q[g] <= res_data;
            end
        end
    end
endmodule

// File: rtl/tri_stream_tdm.sv
module tri_stream_tdm
    import tsm_pkg::*;
#(
    parameter int SAMP_W  = 12,
    parameter int SYM_LEN = 64,
    parameter int RES_W   = 16
) (
    input  logic                              wr_clk,
    input  logic                              wr_rst,
    input  logic [NUM_STREAMS-1:0]            in_vld,
    input  logic [NUM_STREAMS-1:0][SAMP_W-1:0] in_re,
    input  logic [NUM_STREAMS-1:0][SAMP_W-1:0] in_im,
    input  logic                              rd_clk,
    input  logic                              rd_rst,
    output logic                              out_vld,
    output logic [TAG_W-1:0]                  out_tag,
    output logic [SAMP_W-1:0]                 out_re,
    output logic [SAMP_W-1:0]                 out_im,
    input  logic                              res_in_vld,
    input  logic [TAG_W-1:0]                  res_in_tag,
    input  logic [RES_W-1:0]                  res_in_data,
    output logic [NUM_STREAMS-1:0][RES_W-1:0] res_q,
    output logic [NUM_STREAMS-1:0]            res_q_vld
);
    localparam int NS = NUM_STREAMS;
    localparam int AW = $clog2(SYM_LEN) + 1;
    localparam int DW = 2 * SAMP_W;

    logic                 we;
    logic [AW-1:0]        waddr;
    logic                 done_tog;
    logic                 ren;
    logic [AW-1:0]        raddr;
    logic [NS-1:0][DW-1:0] rdata;
    logic [DW-1:0]        out_data;

    tsm_writer #(.NS(NS), .SYM_LEN(SYM_LEN)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .in_vld(in_vld),
        .we(we), .waddr(waddr), .done_tog(done_tog)
    );

    for (genvar g = 0; g < NS; g++) begin : g_buf
        tsm_dpram #(.DW(DW), .AW(AW)) u_ram (
            .wr_clk(wr_clk), .we(we), .waddr(waddr),
            .wdata({in_re[g], in_im[g]}),
            .rd_clk(rd_clk), .re(ren), .raddr(raddr), .rdata(rdata[g])
        );
    end

    tsm_reader #(.NS(NS), .SYM_LEN(SYM_LEN), .DW(DW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .done_tog(done_tog), .rdata(rdata),
        .ren(ren), .raddr(raddr), .out_vld(out_vld), .out_tag(out_tag),
        .out_data(out_data)
    );

    assign out_re = out_data[DW-1:SAMP_W];
    assign out_im = out_data[SAMP_W-1:0];

    tsm_demux #(.NS(NS), .RES_W(RES_W)) u_dmx (
        .clk(rd_clk), .rst(rd_rst), .res_vld(res_in_vld),
        .res_tag(res_in_tag), .res_data(res_in_data),
        .res_q(res_q), .res_q_vld(res_q_vld)
    );
endmodule

// File: rtl/tsm_checker.sv
module tsm_checker #(
    parameter int NS    = 3,
    parameter int RES_W = 16
) (
    input logic                     wr_clk,
    input logic                     wr_rst,
    input logic [NS-1:0]            in_vld,
    input logic                     rd_clk,
    input logic                     rd_rst,
    input logic                     out_vld,
    input logic [1:0]               out_tag,
    input logic                     res_in_vld,
    input logic [1:0]               res_in_tag,
    input logic [RES_W-1:0]         res_in_data,
    input logic [NS-1:0][RES_W-1:0] res_q,
    input logic [NS-1:0]            res_q_vld
);
    // R6: valids move together
    assert_vld_aligned_R6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (in_vld == '0) || (&in_vld));

    assert_tag_range_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        out_vld |-> out_tag != 2'd3);

    assert_tag_order_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (out_vld && $past(out_vld) && out_tag != $past(out_tag))
            |-> out_tag == $past(out_tag) + 2'd1);

    assert_burst_start_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(out_vld) |-> out_tag == 2'd0);

    assert_burst_end_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(out_vld) |-> $past(out_tag) == 2'(NS - 1));

    assert_flag_onehot_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $onehot0(res_q_vld));

    assert_tag3_ignored_R8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (res_in_vld && res_in_tag == 2'd3) |=> res_q_vld == '0);

    for (genvar g = 0; g < NS; g++) begin : g_lane
        assert_load_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
            (res_in_vld && res_in_tag == 2'(g))
                |=> (res_q_vld[g] && res_q[g] == $past(res_in_data)));

        assert_hold_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
            !(res_in_vld && res_in_tag == 2'(g))
                |=> (!res_q_vld[g] && $stable(res_q[g])));
    end
endmodule

bind tri_stream_tdm tsm_checker #(.NS(NS), .RES_W(RES_W)) u_chk (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .in_vld(in_vld),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .out_vld(out_vld), .out_tag(out_tag),
    .res_in_vld(res_in_vld), .res_in_tag(res_in_tag), .res_in_data(res_in_data),
    .res_q(res_q), .res_q_vld(res_q_vld)
);

// File: tb/tb_tri_stream_tdm.sv
module tb_tri_stream_tdm;
    localparam int SW   = 12;
    localparam int SL   = 64;
    localparam int RW   = 16;
    localparam int NS   = 3;
    localparam int NSYM = 5;

    logic                  wr_clk = 1'b0;
    logic                  rd_clk = 1'b0;
    logic                  wr_rst = 1'b1;
    logic                  rd_rst = 1'b1;
    logic [NS-1:0]         in_vld = '0;
    logic [NS-1:0][SW-1:0] in_re = '0;
    logic [NS-1:0][SW-1:0] in_im = '0;
    logic                  out_vld;
    logic [1:0]            out_tag;
    logic [SW-1:0]         out_re, out_im;
    logic                  res_in_vld = 1'b0;
    logic [1:0]            res_in_tag = '0;
    logic [RW-1:0]         res_in_data = '0;
    logic [NS-1:0][RW-1:0] res_q;
    logic [NS-1:0]         res_q_vld;

    int checks = 0;
    int fails  = 0;
    int sym_done = 0;
    int out_cnt = 0;
    int exp_k = 0, exp_s = 0, exp_i = 0;
    bit gap_seen = 0;
    bit mon_en = 0;
    bit finished = 0;

    always #4  rd_clk = ~rd_clk;
    always #12 wr_clk = ~wr_clk;

    tri_stream_tdm #(.SAMP_W(SW), .SYM_LEN(SL), .RES_W(RW)) dut (.*);

    function automatic logic [SW-1:0] f_re(int s, int k, int i);
        return SW'((s * 701 + k * 67 + i * 13 + 5) % 4096);
    endfunction
    function automatic logic [SW-1:0] f_im(int s, int k, int i);
        return SW'((s * 389 + k * 151 + i * 29 + 900) % 4096);
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // one symbol, optionally with idle cycles every 'gap' samples
    task automatic send_sym(int k, int gap, int count);
        for (int i = 0; i < count; i++) begin
            if (gap != 0 && (i % gap) == 1) begin
                @(negedge wr_clk);
                in_vld = '0;
                in_re  = '1;
                in_im  = '1;
            end
            @(negedge wr_clk);
            in_vld = '1;
            for (int s = 0; s < NS; s++) begin
                in_re[s] = f_re(s, k, i);
                in_im[s] = f_im(s, k, i);
            end
        end
        @(negedge wr_clk);
        in_vld = '0;
        if (count == SL) sym_done++;
    endtask

    // readout monitor: R2, R3, R4, R5, R6
    always @(negedge rd_clk) begin
        if (mon_en) begin
            if (out_vld) begin
                out_cnt++;
                if (exp_s == 0 && exp_i == 0)
                    chk(exp_k < sym_done, "R2 readout before symbol complete", exp_k, sym_done);
                chk(out_tag == 2'(exp_s), "R3 tag", out_tag, exp_s);
                chk({out_re, out_im} == {f_re(exp_s, exp_k, exp_i), f_im(exp_s, exp_k, exp_i)},
                    (exp_k % 2 == 1) ? "R6 data with idle cycles" : "R5 data",
                    {out_re, out_im}, {f_re(exp_s, exp_k, exp_i), f_im(exp_s, exp_k, exp_i)});
                if (exp_i == SL - 1) begin
                    exp_i = 0;
                    if (exp_s == NS - 1) begin
                        exp_s = 0;
                        exp_k++;
                        chk(!gap_seen, "R4 contiguous readout", gap_seen, 0);
                        gap_seen = 0;
                    end else exp_s++;
                end else exp_i++;
            end else if (exp_s != 0 || exp_i != 0) begin
                gap_seen = 1;
            end
        end
    end

    task automatic send_res(int t, logic [RW-1:0] d);
        @(negedge rd_clk);
        res_in_vld  = 1'b1;
        res_in_tag  = 2'(t);
        res_in_data = d;
    endtask

    initial begin
        logic [NS-1:0][RW-1:0] hold;
        repeat (6) @(negedge wr_clk);
        chk(out_vld == 1'b0, "R1 out_vld in reset", out_vld, 0);
        chk(res_q_vld == '0, "R1 res_q_vld in reset", res_q_vld, 0);
        chk(res_q == '0, "R1 res_q in reset", res_q, 0);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        mon_en = 1'b1;
        @(negedge rd_clk);
        chk(out_vld == 1'b0 && res_q_vld == '0, "R1 after reset", out_vld, 0);

        for (int k = 0; k < NSYM; k++) begin
            send_sym(k, (k % 2 == 1) ? (k + 2) : 0, SL);
            if (k == 2) repeat (3) @(negedge wr_clk);
        end
        // partial symbol: must not be read out
        send_sym(NSYM, 0, SL / 2);
        repeat (400) @(negedge rd_clk);
        chk(out_cnt == NSYM * NS * SL, "R2 output count (partial symbol ignored)", out_cnt, NSYM * NS * SL);
        chk(exp_k == NSYM, "R5 symbols read", exp_k, NSYM);

        // result demultiplexing
        for (int t = 0; t < NS; t++) begin
            send_res(t, RW'(16'h1234 + t * 16'h1111));
            @(negedge rd_clk);
            res_in_vld = 1'b0;
            chk(res_q_vld == NS'(1 << t), "R7 flag", res_q_vld, 1 << t);
            chk(res_q[t] == RW'(16'h1234 + t * 16'h1111), "R7 load", res_q[t], 16'h1234 + t * 16'h1111);
            @(negedge rd_clk);
            chk(res_q_vld == '0, "R7 one-cycle flag", res_q_vld, 0);
        end
        hold = res_q;
        send_res(3, 16'hDEAD);
        @(negedge rd_clk);
        res_in_vld = 1'b0;
        chk(res_q_vld == '0, "R8 tag3 flag", res_q_vld, 0);
        chk(res_q == hold, "R8 tag3 registers", res_q, hold);
        // back to back, other lanes untouched
        send_res(2, 16'hA5A5);
        send_res(0, 16'h5A5A);
        chk(res_q[2] == 16'hA5A5 && res_q_vld == 3'b100, "R7 back-to-back first", res_q[2], 16'hA5A5);
        chk(res_q[1] == hold[1], "R7 other lane unchanged", res_q[1], hold[1]);
        @(negedge rd_clk);
        res_in_vld = 1'b0;
        chk(res_q[0] == 16'h5A5A && res_q_vld == 3'b001, "R7 back-to-back second", res_q[0], 16'h5A5A);
        chk(res_q[2] == 16'hA5A5, "R7 earlier lane held", res_q[2], 16'hA5A5);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge rd_clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule